// File: doc/BRIEF.md
# Shadowed PWM Register File

This block is the register front end of a pulse-width modulator. A simple single-cycle bus reaches four word-addressed registers: a control word carrying the enable bit, a period count, a high-time (duty) count and a status word with two sticky event flags. The counter that actually produces the waveform lives in a separate core. That core receives the enable bit and the active period and duty values from this block. It returns a one-cycle strobe that marks the end of each of its periods.

Software writes to the period and duty registers land in shadow copies. While the peripheral runs, the shadow copies reach the active outputs only in the cycle after a period-end strobe. The core therefore never sees a new value partway through a period. While the peripheral is stopped, the active values follow the shadows every cycle, so the first period after start-up uses the latest programmed values.

A duty count larger than the period is handled as a defined case: the active duty is clamped to the period, which gives a permanently high output, and the error flag is raised. Both flags are cleared by writing a one to their bit position.

Top module: `pwm_shadow_regs`

## Requirements
- R1: After reset, the enable output, both active outputs, both shadow values, the status flags and the read data are all zero.
- R2: Word index 0 is control, with bit 0 as enable; its other bits are not stored and read back as zero. Index 1 is the period and index 2 is the duty; reads of these two return the shadow (last written) value. Index 3 is status, with bit 0 as the done flag and bit 1 as the error flag.
- R3: A read of a word index of 4 or higher returns zero, and a write to such an index changes no register.
- R4: While enabled, the active period and duty change only in the cycle after a period-end strobe, and they take the shadow values held when the strobe arrives. A shadow write made in the same cycle as the strobe is committed at the following strobe.
- R5: While disabled, the active period and duty take the shadow values one cycle after those shadows change, whether or not strobes arrive.
- R6: When a committed duty exceeds the period, the active duty equals the active period. A commit at a period-end strobe while enabled with such a duty also sets the error flag.
- R7: Each period-end strobe while enabled sets the done flag. A strobe while disabled sets no flag.
- R8: A write to status clears each flag whose write-data bit is 1 and leaves flags whose bit is 0 unchanged. When a flag is set and cleared in the same cycle, it ends up set.
- R9: Read data is registered. It carries the addressed value in the cycle after the read strobe, returns the value from before any write in that same cycle, and is zero in a cycle that follows no read strobe.
- R10: The enable output takes control bit 0 in the cycle after a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word index of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| boundary | input | 1 | Period-end strobe from the PWM core |
| pwm_enable | output | 1 | Enable to the PWM core |
| period_active | output | DATA_W | Period value in use by the core |
| duty_active | output | DATA_W | Duty value in use by the core, clamped to the period |

## Verification
The assertions take the period-end strobe as a plain level sampled on each clock, and the bus strobes as one-cycle pulses with the address stable while they are high. No rule is assumed about how the strobe is spaced or how it lines up with bus traffic. The stimulus raises each strobe for exactly one cycle and drives every input away from the active edge. It deliberately overlaps a period-end strobe with a shadow write and with a status clear, because those races carry the ordering rules of R4 and R8. Strobes are also sent while the block is disabled, to confirm that they raise no flag.

// File: rtl/pwm_shreg_pkg.sv
package pwm_shreg_pkg;
    localparam int unsigned PWM_DW     = 32;
    localparam int unsigned PWM_AW     = 4;
    localparam int unsigned NUM_REGS   = 4;
    localparam int unsigned IDX_CTRL   = 0;
    localparam int unsigned IDX_PERIOD = 1;
    localparam int unsigned IDX_DUTY   = 2;
    localparam int unsigned IDX_STATUS = 3;
    localparam int unsigned NUM_FLAGS  = 2;
    localparam int unsigned FLAG_DONE  = 0;
    localparam int unsigned FLAG_ERR   = 1;
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NREG   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_i,
    input  logic                       rd_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NREG-1:0][DATA_W-1:0] regs_i,
    output logic [NREG-1:0]            wsel_o,
    output logic [DATA_W-1:0]          rdata_o
);
    localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      hit;

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wsel_o[g] = wr_i && (addr_i == ADDR_W'(g));
    end

    assign hit = (32'(addr_i) < 32'(NREG));

    always_comb begin
        st_d = '0;
        if (rd_i && hit) begin
            st_d.rdata = regs_i[addr_i[SEL_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/pwm_shadow_commit.sv
module pwm_shadow_commit #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl_i,
    input  logic              wr_period_i,
    input  logic              wr_duty_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              boundary_i,
    output logic              enable_o,
    output logic [DATA_W-1:0] shd_period_o,
    output logic [DATA_W-1:0] shd_duty_o,
    output logic [DATA_W-1:0] act_period_o,
    output logic [DATA_W-1:0] act_duty_o,
    output logic              commit_evt_o,
    output logic              bad_duty_evt_o
);
    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] shd_p;
        logic [DATA_W-1:0] shd_d;
        logic [DATA_W-1:0] act_p;
        logic [DATA_W-1:0] act_d;
    } cm_state_t;

    cm_state_t st_d, st_q;
    logic      over;
    logic      load;
    logic [DATA_W-1:0] duty_fit;

    always_comb begin
        st_d     = st_q;
        over     = (st_q.shd_d > st_q.shd_p);
        duty_fit = over ? st_q.shd_p : st_q.shd_d;
        load     = !st_q.en || boundary_i;

        if (wr_ctrl_i) begin
            st_d.en = wdata_i[0];
        end
        if (wr_period_i) begin
            st_d.shd_p = wdata_i;
        end
        if (wr_duty_i) begin
            st_d.shd_d = wdata_i;
        end
        if (load) begin
            st_d.act_p = st_q.shd_p;
            st_d.act_d = duty_fit;
        end

        commit_evt_o   = st_q.en && boundary_i;
        bad_duty_evt_o = st_q.en && boundary_i && over;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o     = st_q.en;
    assign shd_period_o = st_q.shd_p;
    assign shd_duty_o   = st_q.shd_d;
    assign act_period_o = st_q.act_p;
    assign act_duty_o   = st_q.act_d;
endmodule

// File: rtl/pwm_status_flags.sv
module pwm_status_flags #(
    parameter int unsigned NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    input  logic [NFLAG-1:0] set_i,
    output logic [NFLAG-1:0] flags_o
);
    typedef struct packed {
        logic [NFLAG-1:0] bits;
    } fl_state_t;

    fl_state_t        st_d, st_q;
    logic [NFLAG-1:0] nxt;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        assign nxt[g] = set_i[g] || (st_q.bits[g] && !(clr_wr_i && clr_mask_i[g]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.bits;
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_shreg_pkg::*;
#(
    parameter int unsigned DATA_W = PWM_DW,
    parameter int unsigned ADDR_W = PWM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              boundary,
    output logic              pwm_enable,
    output logic [DATA_W-1:0] period_active,
    output logic [DATA_W-1:0] duty_active
);
    logic [NUM_REGS-1:0]             wsel;
    logic [NUM_REGS-1:0][DATA_W-1:0] rd_regs;
    logic [DATA_W-1:0]               shd_period;
    logic [DATA_W-1:0]               shd_duty;
    logic [NUM_FLAGS-1:0]            flags;
    logic [NUM_FLAGS-1:0]            flag_set;
    logic                            commit_evt;
    logic                            bad_evt;

    pwm_bus_decode #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NREG   (NUM_REGS)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .regs_i  (rd_regs),
        .wsel_o  (wsel),
        .rdata_o (bus_rdata)
    );

    pwm_shadow_commit #(
        .DATA_W (DATA_W)
    ) u_commit (
        .clk            (clk),
        .rst            (rst),
        .wr_ctrl_i      (wsel[IDX_CTRL]),
        .wr_period_i    (wsel[IDX_PERIOD]),
        .wr_duty_i      (wsel[IDX_DUTY]),
        .wdata_i        (bus_wdata),
        .boundary_i     (boundary),
        .enable_o       (pwm_enable),
        .shd_period_o   (shd_period),
        .shd_duty_o     (shd_duty),
        .act_period_o   (period_active),
        .act_duty_o     (duty_active),
        .commit_evt_o   (commit_evt),
        .bad_duty_evt_o (bad_evt)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_DONE] = commit_evt;
        flag_set[FLAG_ERR]  = bad_evt;
    end

    pwm_status_flags #(
        .NFLAG (NUM_FLAGS)
    ) u_flags (
        .clk        (clk),
        .rst        (rst),
        .clr_wr_i   (wsel[IDX_STATUS]),
        .clr_mask_i (bus_wdata[NUM_FLAGS-1:0]),
        .set_i      (flag_set),
        .flags_o    (flags)
    );

    always_comb begin
        rd_regs                                = '0;
        rd_regs[IDX_CTRL][0]                   = pwm_enable;
        rd_regs[IDX_PERIOD]                    = shd_period;
        rd_regs[IDX_DUTY]                      = shd_duty;
        rd_regs[IDX_STATUS][NUM_FLAGS-1:0]     = flags;
    end
endmodule

// File: rtl/pwm_shadow_regs_chk.sv
module pwm_shadow_regs_chk
    import pwm_shreg_pkg::*;
#(
    parameter int unsigned DATA_W = PWM_DW,
    parameter int unsigned ADDR_W = PWM_AW
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 wdata_b0,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 boundary,
    input logic                 pwm_enable,
    input logic [DATA_W-1:0]    period_active,
    input logic [DATA_W-1:0]    duty_active,
    input logic [DATA_W-1:0]    shd_period,
    input logic [DATA_W-1:0]    shd_duty,
    input logic [NUM_FLAGS-1:0] flags
);
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwm_enable && !boundary) |=> ($stable(period_active) && $stable(duty_active))); // R4

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !pwm_enable |=> (period_active == $past(shd_period))); // R5

    AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (duty_active <= period_active)); // R6

    AST_DUTY_CLAMP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (duty_active <= period_active)); // R6

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (pwm_enable && boundary && (shd_duty > shd_period)) |=> flags[FLAG_ERR]); // R6

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        (pwm_enable && boundary) |=> flags[FLAG_DONE]); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[FLAG_DONE] && !(bus_wr && (bus_addr == ADDR_W'(IDX_STATUS)) && wdata_b0))
        |=> flags[FLAG_DONE]); // R8

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0)); // R9

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        (!pwm_enable && !flags[FLAG_DONE]) |=> !flags[FLAG_DONE]); // R7
endmodule

bind pwm_shadow_regs pwm_shadow_regs_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .wdata_b0      (bus_wdata[0]),
    .bus_rdata     (bus_rdata),
    .boundary      (boundary),
    .pwm_enable    (pwm_enable),
    .period_active (period_active),
    .duty_active   (duty_active),
    .shd_period    (shd_period),
    .shd_duty      (shd_duty),
    .flags         (flags)
);

// File: tb/pwm_shadow_regs_test.sv
`timescale 1ns/1ps
module pwm_shadow_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        boundary = 1'b0;
    logic        pwm_enable;
    logic [31:0] period_active;
    logic [31:0] duty_active;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwm_shadow_regs uut (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .boundary      (boundary),
        .pwm_enable    (pwm_enable),
        .period_active (period_active),
        .duty_active   (duty_active)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung, got=%0d exp<=20000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 enable", {31'b0, pwm_enable}, 0);
        check("R1 period_active", period_active, 0);
        check("R1 duty_active", duty_active, 0);
        check("R1 rdata", bus_rdata, 0);
        for (int i = 0; i < 4; i++) begin
            rd_reg(i[3:0], v);
            check("R1 register", v, 0);
        end
    endtask

    task automatic t_idle_follow();
        logic [31:0] v;
        wr_reg(4'd1, 32'd100);
        wr_reg(4'd2, 32'd30);
        @(negedge clk);
        check("R5 period follows", period_active, 32'd100);
        check("R5 duty follows", duty_active, 32'd30);
        strobe();
        rd_reg(4'd3, v);
        check("R7 no flag while disabled", v, 0);
        rd_reg(4'd1, v);
        check("R2 period readback", v, 32'd100);
        wr_reg(4'd0, 32'hFFFF_FFFE);
        check("R10 enable stays low", {31'b0, pwm_enable}, 0);
        rd_reg(4'd0, v);
        check("R2 ctrl upper bits", v, 0);
    endtask

    task automatic t_hold_commit();
        logic [31:0] v;
        wr_reg(4'd0, 32'd1);
        check("R10 enable set", {31'b0, pwm_enable}, 1);
        wr_reg(4'd1, 32'd200);
        wr_reg(4'd2, 32'd50);
        repeat (5) @(negedge clk);
        check("R4 period held", period_active, 32'd100);
        check("R4 duty held", duty_active, 32'd30);
        rd_reg(4'd2, v);
        check("R2 duty reads shadow", v, 32'd50);
        strobe();
        check("R4 period commit", period_active, 32'd200);
        check("R4 duty commit", duty_active, 32'd50);
        rd_reg(4'd3, v);
        check("R7 done set", v, 32'd1);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        wr_reg(4'd3, 32'd3);
        wr_reg(4'd2, 32'd300);
        check("R4 duty held before strobe", duty_active, 32'd50);
        strobe();
        check("R6 duty clamped", duty_active, 32'd200);
        check("R6 period kept", period_active, 32'd200);
        rd_reg(4'd3, v);
        check("R6 error and done", v, 32'd3);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr_reg(4'd3, 32'd2);
        rd_reg(4'd3, v);
        check("R8 clear error only", v, 32'd1);
        wr_reg(4'd3, 32'd0);
        rd_reg(4'd3, v);
        check("R8 zero write keeps", v, 32'd1);
        wr_reg(4'd3, 32'd1);
        rd_reg(4'd3, v);
        check("R8 clear done", v, 32'd0);
        @(negedge clk);
        boundary = 1'b1; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'd3;
        @(negedge clk);
        boundary = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd_reg(4'd3, v);
        check("R8 set wins over clear", v, 32'd3);
        wr_reg(4'd3, 32'd3);
    endtask

    task automatic t_race();
        logic [31:0] v;
        @(negedge clk);
        boundary = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'd400;
        @(negedge clk);
        boundary = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        check("R4 race commits old period", period_active, 32'd200);
        check("R4 race duty clamp", duty_active, 32'd200);
        wr_reg(4'd3, 32'd3);
        strobe();
        check("R4 late period commit", period_active, 32'd400);
        check("R4 late duty commit", duty_active, 32'd300);
        rd_reg(4'd3, v);
        check("R6 no error when duty fits", v, 32'd1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr_reg(4'd5, 32'hFFFF_FFFF);
        wr_reg(4'd15, 32'hFFFF_FFFF);
        rd_reg(4'd5, v);
        check("R3 unmapped read", v, 0);
        rd_reg(4'd15, v);
        check("R3 top index read", v, 0);
        rd_reg(4'd1, v);
        check("R3 period untouched", v, 32'd400);
        rd_reg(4'd2, v);
        check("R3 duty untouched", v, 32'd300);
        rd_reg(4'd0, v);
        check("R3 ctrl untouched", v, 32'd1);
        rd_reg(4'd3, v);
        check("R3 status untouched", v, 32'd1);
    endtask

    task automatic t_read_timing();
        logic [31:0] v;
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'd77;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        check("R9 read before write", bus_rdata, 32'd300);
        @(negedge clk);
        check("R9 idle rdata zero", bus_rdata, 0);
        rd_reg(4'd2, v);
        check("R9 new value read", v, 32'd77);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr_reg(4'd3, 32'd3);
        wr_reg(4'd0, 32'd0);
        check("R10 enable cleared", {31'b0, pwm_enable}, 0);
        @(negedge clk);
        check("R5 duty follows after stop", duty_active, 32'd77);
        strobe();
        strobe();
        rd_reg(4'd3, v);
        check("R7 no done while disabled", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle_follow();
        t_hold_commit();
        t_clamp();
        t_w1c();
        t_race();
        t_unmapped();
        t_read_timing();
        t_disable();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule